// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block drives the row strobe, column strobe, write enable and address lines of an asynchronous DRAM array whenever the array needs start-up or refresh work. After reset it holds every strobe high and waits for a fixed settling pause. It then runs a burst of CAS-before-RAS cycles to bring the array's internal row counter into use. It raises `ready` once that burst is over. From that point a free-running interval timer marks each refresh as due. The due refreshes are tallied in a small pending counter.

The access controller arbitrates through a request/grant pair that works like a valid/ready handshake. `ref_req` acts as valid and `ref_gnt` acts as ready. A refresh cycle starts on the clock edge where both are high. `ref_req` stays high until it is accepted. A grant with no request has no effect. While a cycle runs, `bus_own` is high and `ref_req` is low. If the pending tally reaches its limit, `ref_urgent` goes high and the sequencer starts a cycle without waiting for a grant. The controller must give up the lines at once.

Every timing value is a count of clock cycles and is set by a parameter. The defaults assume a 4 ns clock: a 100 µs pause, 3900-cycle spacing (4096 rows in 64 ms), a 12 ns column-strobe lead, an 8 ns column hold, a 52 ns row-low time and a 32 ns precharge.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low (asynchronous), `ras_n`, `cas_n` and `we_n` are 1, and `ready`, `ref_req`, `ref_urgent` and `bus_own` are 0.
- R2: After reset is released, `cas_n` and `ras_n` stay high for at least PAUSE_CYC clock cycles.
- R3: After the pause, INIT_CYCLES refresh cycles run without any grant. `ready` rises after the last one, with `ras_n` high, and then stays high until the next reset.
- R4: While `ready` is 0, `ref_req` and `ref_urgent` are 0, whatever `ref_gnt` does.
- R5: In each refresh cycle `cas_n` goes low at least CSR_CYC cycles before `ras_n` falls, stays low for CHR_CYC cycles after `ras_n` falls, and rises while `ras_n` is still low. `we_n` is 1 throughout.
- R6: `ras_n` stays low for exactly RAS_CYC cycles. Between `ras_n` rising and the next fall of `cas_n`, at least RP_CYC cycles pass.
- R7: Once `ready` is high, one refresh falls due every INTERVAL_CYC cycles. With `ref_gnt` held at 1, successive `ref_req` pulses are exactly INTERVAL_CYC cycles apart.
- R8: `ref_req` is 1 whenever a refresh is pending and no cycle is running, and it holds until it is granted. Each accepted grant serves one pending refresh. `ref_req` drops once none remain.
- R9: Refreshes that fall due while the grant is withheld accumulate, up to PEND_MAX. When the grant comes, that many refresh cycles follow back to back.
- R10: When PEND_MAX refreshes are pending, `ref_urgent` is 1 and a refresh cycle starts on the next edge with `ref_gnt` at 0. This lowers the tally by one.
- R11: `addr` is always all-zero, and `bus_own` is 1 whenever `ras_n` or `cas_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access controller yields the DRAM lines (ready side of the handshake) |
| ref_req | output | 1 | A refresh is pending and waiting for the lines (valid side) |
| ref_urgent | output | 1 | Pending limit reached; the sequencer takes the lines without a grant |
| ready | output | 1 | Start-up sequence complete; normal access allowed |
| bus_own | output | 1 | Sequencer is driving a refresh cycle on the DRAM lines |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| addr | output | ADDR_W | Address bus, driven to zero |

## Verification
The forced refresh is the hardest state to reach. It only occurs after PEND_MAX interval ticks have passed with no grant. Each stimulus vector waits for a `ref_req` edge to lock onto the tick phase. It then withholds the grant for a computed number of whole and half intervals, so the bench knows exactly how many refreshes are due. It counts row-strobe falls seen while the grant is low, and then again after it is granted. A separate step asserts reset in the middle of a row-low phase to show that the strobes return high asynchronously.

// File: rtl/dramseq_pkg.sv
package dramseq_pkg;
  typedef enum logic [2:0] {
    CBR_IDLE,
    CBR_CSETUP,
    CBR_CHOLD,
    CBR_RLOW,
    CBR_PRECH
  } cbr_state_t;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_INIT,
    PH_RUN
  } seq_phase_t;
endpackage

// File: rtl/dramseq_timer.sv
module dramseq_timer #(
  parameter int unsigned PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R7: the phase counter never leaves its period
  a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < PERIOD);
  // R7: a disabled timer restarts from zero
  a_r7_restart_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);
endmodule

// File: rtl/dramseq_pending.sv
module dramseq_pending #(
  parameter int unsigned MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero,
  output logic full
);
  localparam int unsigned CW = $clog2(MAX + 1);

  logic [CW-1:0] cnt;
  logic          up, down;

  assign nonzero = (cnt != '0);
  assign full    = (cnt == CW'(MAX));
  assign down    = dec && nonzero;
  assign up      = inc && (!full || down);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (up && !down)   cnt <= cnt + 1'b1;
    else if (down && !up)   cnt <= cnt - 1'b1;
  end

  // R9: the tally is bounded by its limit
  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= MAX);
  // R9: a due refresh with nothing served never loses count below the limit
  a_r9_accumulates: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !full) |=> nonzero);
endmodule

// File: rtl/dramseq_cbr.sv
module dramseq_cbr
  import dramseq_pkg::*;
#(
  parameter int unsigned CSR_CYC = 3,
  parameter int unsigned CHR_CYC = 2,
  parameter int unsigned RAS_CYC = 13,
  parameter int unsigned RP_CYC  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned RLOW_CYC = RAS_CYC - CHR_CYC;
  localparam int unsigned M1 = (CSR_CYC > CHR_CYC) ? CSR_CYC : CHR_CYC;
  localparam int unsigned M2 = (RLOW_CYC > RP_CYC) ? RLOW_CYC : RP_CYC;
  localparam int unsigned MAXLEN = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;

  cbr_state_t    state, nxt_state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          last;

  always_comb begin
    lim       = CW'(1);
    nxt_state = CBR_IDLE;
    case (state)
      CBR_CSETUP: begin lim = CW'(CSR_CYC);  nxt_state = CBR_CHOLD; end
      CBR_CHOLD:  begin lim = CW'(CHR_CYC);  nxt_state = CBR_RLOW;  end
      CBR_RLOW:   begin lim = CW'(RLOW_CYC); nxt_state = CBR_PRECH; end
      CBR_PRECH:  begin lim = CW'(RP_CYC);   nxt_state = CBR_IDLE;  end
      default:    begin lim = CW'(1);        nxt_state = CBR_IDLE;  end
    endcase
  end

  assign last = (cnt == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CBR_IDLE;
      cnt   <= '0;
    end else if (state == CBR_IDLE) begin
      cnt <= '0;
      if (start) state <= CBR_CSETUP;
    end else if (last) begin
      cnt   <= '0;
      state <= nxt_state;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign busy  = (state != CBR_IDLE);
  assign done  = (state == CBR_PRECH) && last;
  assign cas_n = !((state == CBR_CSETUP) || (state == CBR_CHOLD));
  assign ras_n = !((state == CBR_CHOLD) || (state == CBR_RLOW));
  assign we_n  = 1'b1;

  // R5: the column strobe is already low, and was low a cycle earlier, when the row strobe falls
  a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n)));
  // R5: the column strobe rises before the row strobe does
  a_r5_cas_rises_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);
  // R6: after the row strobe rises, the column strobe stays high in the next cycle
  a_r6_precharge_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> cas_n);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dramseq_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 25000,
  parameter int unsigned INTERVAL_CYC = 3900,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned PEND_MAX     = 4,
  parameter int unsigned CSR_CYC      = 3,
  parameter int unsigned CHR_CYC      = 2,
  parameter int unsigned RAS_CYC      = 13,
  parameter int unsigned RP_CYC       = 8,
  parameter int unsigned ADDR_W       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic              ready,
  output logic              bus_own,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned ICW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;

  seq_phase_t     phase;
  logic [ICW-1:0] init_cnt;
  logic           pause_tick, due_tick;
  logic           pend_nz, pend_full;
  logic           cbr_busy, cbr_done, cbr_start, run_start;

  dramseq_timer #(.PERIOD(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_PAUSE), .tick(pause_tick));

  dramseq_timer #(.PERIOD(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst_n(rst_n), .en(phase == PH_RUN), .tick(due_tick));

  dramseq_pending #(.MAX(PEND_MAX)) u_pending (
    .clk(clk), .rst_n(rst_n), .inc(due_tick), .dec(run_start),
    .nonzero(pend_nz), .full(pend_full));

  dramseq_cbr #(
    .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_cbr (
    .clk(clk), .rst_n(rst_n), .start(cbr_start), .busy(cbr_busy),
    .done(cbr_done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  assign run_start = (phase == PH_RUN) && !cbr_busy && pend_nz && (ref_gnt || pend_full);
  assign cbr_start = run_start || ((phase == PH_INIT) && !cbr_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_PAUSE;
      init_cnt <= '0;
    end else begin
      case (phase)
        PH_PAUSE: if (pause_tick) begin
          phase    <= PH_INIT;
          init_cnt <= '0;
        end
        PH_INIT: if (cbr_done) begin
          if (init_cnt == ICW'(INIT_CYCLES - 1)) phase <= PH_RUN;
          else                                   init_cnt <= init_cnt + 1'b1;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign ready      = (phase == PH_RUN);
  assign ref_req    = ready && pend_nz && !cbr_busy;
  assign ref_urgent = ready && pend_full;
  assign bus_own    = cbr_busy;
  assign addr       = '0;

  // R4: nothing is offered to the access controller before start-up completes
  a_r4_quiet_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!ref_req && !ref_urgent));
  // R3: ready never falls without a reset
  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  // R8: a run-time refresh starts only on a grant or when forced
  a_r8_start_authorised: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_own) && $past(ready)) |-> ($past(ref_gnt) || $past(ref_urgent)));
  // R10: a full tally takes the lines on the next edge
  a_r10_urgent_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent && !bus_own) |=> bus_own);
  // R11: any low strobe happens inside an owned cycle
  a_r11_strobes_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> bus_own);
endmodule

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;
  localparam int PAUSE = 40;
  localparam int L     = 200;
  localparam int NINIT = 8;
  localparam int PMAX  = 4;
  localparam int CSR   = 3;
  localparam int CHR   = 2;
  localparam int RAS   = 13;
  localparam int RP    = 8;
  localparam int AW    = 12;

  // {withheld intervals, expected forced cycles while withheld, expected cycles after grant}
  localparam int VEC [5][3] = '{'{1,0,1}, '{2,0,2}, '{3,0,3}, '{4,1,3}, '{5,2,3}};

  logic clk = 0, rst_n = 0, ref_gnt = 0;
  logic ref_req, ref_urgent, ready, bus_own, ras_n, cas_n, we_n;
  logic [AW-1:0] addr;

  int nchk = 0, nfail = 0;
  int nfall = 0;
  bit urg_seen = 0;
  int own_err = 0, addr_err = 0, drop_err = 0, pre_err = 0;
  bit prev_ras = 1, prev_cas = 1, seen_rise = 0, ready_was = 0;
  int cas_run = 0, ras_run = 0, hi_run = 0;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(L), .INIT_CYCLES(NINIT), .PEND_MAX(PMAX),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RAS), .RP_CYC(RP), .ADDR_W(AW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .ready(ready), .bus_own(bus_own),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr));

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1; prev_cas = 1; cas_run = 0; ras_run = 0; hi_run = 0;
      seen_rise = 0; ready_was = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        nfall++;
        check(cas_run >= CSR && !cas_n && we_n, "R5 cas lead", cas_run, CSR);
      end
      if (!prev_cas && cas_n && !ras_n)
        check(ras_run == CHR, "R5 cas hold", ras_run, CHR);
      if (!prev_ras && ras_n) begin
        check(ras_run == RAS, "R6 ras low width", ras_run, RAS);
        seen_rise = 1;
      end
      if (prev_cas && !cas_n && seen_rise)
        check(hi_run >= RP, "R6 precharge", hi_run, RP);
      if (ref_urgent) urg_seen = 1;
      if ((!ras_n || !cas_n) && !bus_own) own_err++;
      if (addr != '0) addr_err++;
      if (!we_n) own_err++;
      if (ready_was && !ready) drop_err++;
      if (!ready && (ref_req || ref_urgent)) pre_err++;
      ready_was = ready;
      cas_run = cas_n ? 0 : cas_run + 1;
      ras_run = ras_n ? 0 : ras_run + 1;
      hi_run  = ras_n ? hi_run + 1 : 0;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic pause_and_init();
    int c = 0;
    nfall = 0;
    @(negedge clk) rst_n = 1;
    while (cas_n) begin @(negedge clk); c++; end
    check(c >= PAUSE, "R2 pause length", c, PAUSE);
    while (!ready) @(negedge clk);
    check(nfall == NINIT, "R3 init cycle count", nfall, NINIT);
    check(ras_n && cas_n && !bus_own, "R3 ready after last cycle", ras_n, 1);
    check(pre_err == 0, "R4 no request before ready", pre_err, 0);
  endtask

  initial begin
    rst_n = 0;
    ref_gnt = 1;
    repeat (5) @(negedge clk);
    check(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    check(!ready && !ref_req && !ref_urgent && !bus_own, "R1 flags low in reset",
          {ready, ref_req, ref_urgent, bus_own}, 0);
    pause_and_init();
    ref_gnt = 0;

    for (int i = 0; i < 5; i++) begin
      int w, req_lost;
      w = VEC[i][0];
      req_lost = 0;
      while (!ref_req) @(negedge clk);
      nfall = 0;
      urg_seen = 0;
      repeat ((w - 1) * L + L / 2) begin
        @(negedge clk);
        if (!ref_req && !bus_own) req_lost++;
      end
      check(req_lost == 0, "R8 request held while withheld", req_lost, 0);
      check(nfall == VEC[i][1], "R10 forced cycles without grant", nfall, VEC[i][1]);
      check(urg_seen == (VEC[i][1] > 0), "R10 urgent flag", urg_seen, VEC[i][1] > 0);
      ref_gnt = 1;
      nfall = 0;
      repeat (90) @(negedge clk);
      ref_gnt = 0;
      check(nfall == VEC[i][2], "R9 back-to-back cycles on grant", nfall, VEC[i][2]);
      check(!ref_req, "R8 request drops when served", ref_req, 0);
    end

    begin
      int n;
      ref_gnt = 1;
      while (!ref_req) @(negedge clk);
      @(negedge clk);
      n = 1;
      while (!ref_req) begin @(negedge clk); n++; end
      check(n == L, "R7 refresh spacing", n, L);
    end

    check(own_err == 0, "R11 strobes only in owned cycles, we_n high", own_err, 0);
    check(addr_err == 0, "R11 address zero", addr_err, 0);
    check(drop_err == 0, "R3 ready sticky", drop_err, 0);
    check(pre_err == 0, "R4 quiet before ready", pre_err, 0);

    while (ras_n) @(negedge clk);
    rst_n = 0;
    #1;
    check(ras_n && cas_n && we_n, "R1 async reset mid-cycle", {ras_n, cas_n, we_n}, 7);
    check(!ready && !ref_req && !bus_own, "R1 flags cleared", {ready, ref_req, bus_own}, 0);
    repeat (3) @(negedge clk);
    pause_and_init();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule